// File: doc/BRIEF.md
# Frame Destination Address Filter

This block decides whether a received frame should be kept, based only on its 48-bit destination address. When a start strobe arrives, the block samples the address together with the low bits of a CRC-32 that an upstream generator has already computed over the six address bytes. Exactly one cycle later it raises a valid strobe and an accept flag.

The decision draws on several sources. A station slot holds the node's own unicast address. Extra exact-match slots hold group addresses. A 64-bit hash table, stored as 16-bit words, covers any further multicast groups. Two mode bits override the filter: one accepts every frame, the other accepts every group address.

All configuration lives in 16-bit registers that a host writes one word at a time. Each slot is loaded as three words. A slot that is not in use is loaded with all ones. When more groups are wanted than there are slots, software sets every hash bit.

Top module: `daf_addr_filter`

## Requirements
- R1: `dec_valid` is high in exactly the cycle after each cycle with `chk_start` high, and is low in every other cycle. `dec_accept` is never high while `dec_valid` is low. Back-to-back starts give back-to-back results.
- R2: After reset, the mode bits are clear, the station slot is all zeros, every extra slot is all ones and the hash table is all zeros. Both outputs are low during reset.
- R3: An address whose bit 0 is 0 (a unicast address) is accepted only when it equals the station slot, or when promiscuous mode is on. A unicast address that equals an extra slot is rejected.
- R4: An address whose bit 0 is 1 (a group address) is accepted when it equals any slot.
- R5: A group address is also accepted when hash word `crc[5:4]` has bit `15 - crc[3:0]` set. Here `crc` is the little-endian CRC-32 of the six address bytes, with byte 0 taken from `chk_dest[7:0]`, fed in LSB first, with all-ones preset and no final inversion. When all four hash words are 0xFFFF, every group address is accepted.
- R6: The broadcast address (all 48 bits set) is always accepted.
- R7: When bit 5 of the mode register (offset 0x00) is set, every frame is accepted (promiscuous mode).
- R8: When bit 8 of the mode register is set, every group address is accepted. Unicast filtering is not changed by this bit.
- R9: The register map is fixed, and every write is one 16-bit word:
  - Mode register at 0x00.
  - Hash word j at 0x10 + 2j.
  - Slot s (s = 0 is the station slot, 1 to 4 are the extra slots) has word k at 0x20 + 8s + 2k. Word k holds `chk_dest[16k+15:16k]`.
  - A write to any other offset changes nothing.
- R10: A configuration write made in the same cycle as a start does not affect that start's decision. It takes effect from the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 16 | Register write data |
| chk_start | input | 1 | Sample the address and start a decision |
| chk_dest | input | 48 | Destination address; bits [7:0] are the first byte on the wire |
| chk_crc_lsb | input | 6 | Low six bits of the little-endian CRC-32 of the address |
| dec_valid | output | 1 | Decision valid, one cycle after `chk_start` |
| dec_accept | output | 1 | Frame accepted; meaningful only while `dec_valid` is high |

## Verification
The bench builds the block with its defaults: four extra slots, four hash words and 8-bit register offsets. With these values the full 64-bit hash is reachable, and so is every slot word through an offset the bench restates from the map. The bench computes the CRC-32 itself, which lets it aim single hash bits at chosen group addresses in each of the four words. Back-to-back starts, and a register write landing on the same edge as a start, exercise the one-cycle timing and the use of the old configuration.

// File: rtl/daf_pkg.sv
package daf_pkg;

  localparam int MAC_W          = 48;
  localparam int WORD_W         = 16;
  localparam int WORDS_PER_SLOT = MAC_W / WORD_W;

  // register map
  localparam int CTRL_OFS     = 'h00;
  localparam int HASH_BASE    = 'h10;
  localparam int SLOT_BASE    = 'h20;
  localparam int SLOT_STRIDE  = 8;
  localparam int PROMISC_BIT  = 5;
  localparam int ALLMULTI_BIT = 8;

  typedef logic [MAC_W-1:0] mac_t;

  // bit position inside a hash word, counted from the top
  function automatic logic [3:0] hash_bit_pos(input logic [3:0] nib);
    return 4'd15 - nib;
  endfunction

  function automatic logic addr_is_group(input mac_t a);
    return a[0];
  endfunction

  function automatic logic addr_is_bcast(input mac_t a);
    return &a;
  endfunction

endpackage

// File: rtl/daf_cfg_regs.sv
module daf_cfg_regs
  import daf_pkg::*;
#(
  parameter int CFG_AW     = 8,
  parameter int NUM_SLOTS  = 5,
  parameter int HASH_WORDS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [CFG_AW-1:0]                   wr_addr,
  input  logic [WORD_W-1:0]                   wr_data,
  output logic [NUM_SLOTS-1:0][MAC_W-1:0]     slots_o,
  output logic [HASH_WORDS*WORD_W-1:0]        hash_o,
  output logic                                promisc_o,
  output logic                                allmulti_o
);

  logic promisc_q;
  logic allmulti_q;
  logic ctrl_hit;

  assign ctrl_hit = wr_en && (wr_addr == CFG_AW'(CTRL_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      promisc_q  <= 1'b0;
      allmulti_q <= 1'b0;
    end else if (ctrl_hit) begin
      promisc_q  <= wr_data[PROMISC_BIT];
      allmulti_q <= wr_data[ALLMULTI_BIT];
    end
  end

  assign promisc_o  = promisc_q;
  assign allmulti_o = allmulti_q;

  // address slots: slot 0 resets to zero, the others to all ones
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar w = 0; w < WORDS_PER_SLOT; w++) begin : g_word
      localparam int OFS = SLOT_BASE + s * SLOT_STRIDE + 2 * w;
      localparam logic [WORD_W-1:0] RST_VAL = (s == 0) ? '0 : '1;
      logic [WORD_W-1:0] word_q;
      logic              hit;
      assign hit = wr_en && (wr_addr == CFG_AW'(OFS));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   word_q <= RST_VAL;
        else if (hit) word_q <= wr_data;
      end
      assign slots_o[s][w*WORD_W +: WORD_W] = word_q;
    end
  end

  // hash table words
  for (genvar j = 0; j < HASH_WORDS; j++) begin : g_hash
    localparam int OFS = HASH_BASE + 2 * j;
    logic [WORD_W-1:0] word_q;
    logic              hit;
    assign hit = wr_en && (wr_addr == CFG_AW'(OFS));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_data;
    end
    assign hash_o[j*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/daf_slot_match.sv
module daf_slot_match
  import daf_pkg::*;
#(
  parameter int NUM_SLOTS = 5
) (
  input  logic [NUM_SLOTS-1:0][MAC_W-1:0] slots_i,
  input  mac_t                            dest_i,
  output logic [NUM_SLOTS-1:0]            hit_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
    assign hit_o[s] = (slots_i[s] == dest_i);
  end

endmodule

// File: rtl/daf_hash_lookup.sv
module daf_hash_lookup
  import daf_pkg::*;
#(
  parameter  int HASH_WORDS = 4,
  localparam int IDX_W      = $clog2(HASH_WORDS)
) (
  input  logic [HASH_WORDS*WORD_W-1:0] table_i,
  input  logic [IDX_W+3:0]             crc_i,
  output logic                         hit_o
);

  logic [IDX_W+3:0] bit_index;

  // upper CRC bits pick the word, the low nibble picks a reversed bit
  assign bit_index = {crc_i[IDX_W+3:4], hash_bit_pos(crc_i[3:0])};
  assign hit_o     = table_i[bit_index];

endmodule

// File: rtl/daf_addr_filter.sv
module daf_addr_filter
  import daf_pkg::*;
#(
  parameter  int CFG_AW     = 8,
  parameter  int NUM_XSLOTS = 4,
  parameter  int HASH_WORDS = 4,
  localparam int HIDX_W     = $clog2(HASH_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [15:0]       cfg_wdata,
  input  logic              chk_start,
  input  logic [47:0]       chk_dest,
  input  logic [HIDX_W+3:0] chk_crc_lsb,
  output logic              dec_valid,
  output logic              dec_accept
);

  localparam int NUM_SLOTS = NUM_XSLOTS + 1;

  logic [NUM_SLOTS-1:0][MAC_W-1:0] slots_w;
  logic [HASH_WORDS*WORD_W-1:0]    hash_w;
  logic [NUM_SLOTS-1:0]            slot_hits_w;
  logic                            promisc_w;
  logic                            allmulti_w;
  logic                            station_hit_w;
  logic                            any_slot_hit_w;
  logic                            hash_hit_w;
  logic                            is_group_w;
  logic                            is_bcast_w;
  logic                            group_pass_w;
  logic                            accept_next_w;
  logic                            valid_q;
  logic                            accept_q;

  daf_cfg_regs #(
    .CFG_AW     (CFG_AW),
    .NUM_SLOTS  (NUM_SLOTS),
    .HASH_WORDS (HASH_WORDS)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_addr    (cfg_addr),
    .wr_data    (cfg_wdata),
    .slots_o    (slots_w),
    .hash_o     (hash_w),
    .promisc_o  (promisc_w),
    .allmulti_o (allmulti_w)
  );

  daf_slot_match #(
    .NUM_SLOTS (NUM_SLOTS)
  ) match_i (
    .slots_i (slots_w),
    .dest_i  (chk_dest),
    .hit_o   (slot_hits_w)
  );

  daf_hash_lookup #(
    .HASH_WORDS (HASH_WORDS)
  ) hash_i (
    .table_i (hash_w),
    .crc_i   (chk_crc_lsb),
    .hit_o   (hash_hit_w)
  );

  assign station_hit_w  = slot_hits_w[0];
  assign any_slot_hit_w = |slot_hits_w;
  assign is_group_w     = addr_is_group(chk_dest);
  assign is_bcast_w     = addr_is_bcast(chk_dest);
  assign group_pass_w   = allmulti_w | any_slot_hit_w | hash_hit_w;
  assign accept_next_w  = promisc_w | is_bcast_w |
                          (is_group_w ? group_pass_w : station_hit_w);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      valid_q  <= chk_start;
      accept_q <= chk_start & accept_next_w;
    end
  end

  assign dec_valid  = valid_q;
  assign dec_accept = accept_q;

endmodule

// File: rtl/daf_filter_checker.sv
module daf_filter_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        chk_start,
  input logic [47:0] chk_dest,
  input logic        dec_valid,
  input logic        dec_accept,
  input logic        promisc_w,
  input logic        allmulti_w,
  input logic        station_hit_w
);

  assert_valid_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    chk_start |=> dec_valid);

  assert_no_stray_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_start |=> !dec_valid);

  assert_accept_within_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_accept |-> dec_valid);

  assert_unicast_needs_station_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_start && !promisc_w && !chk_dest[0] && !station_hit_w) |=> !dec_accept);

  assert_bcast_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_start && (&chk_dest)) |=> dec_accept);

  assert_promisc_keeps_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_start && promisc_w) |=> dec_accept);

  assert_allmulti_keeps_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_start && allmulti_w && chk_dest[0]) |=> dec_accept);

endmodule

bind daf_addr_filter daf_filter_checker chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .chk_start     (chk_start),
  .chk_dest      (chk_dest),
  .dec_valid     (dec_valid),
  .dec_accept    (dec_accept),
  .promisc_w     (promisc_w),
  .allmulti_w    (allmulti_w),
  .station_hit_w (station_hit_w)
);

// File: tb/daf_addr_filter_tb_top.sv
module daf_addr_filter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        chk_start;
  logic [47:0] chk_dest;
  logic [5:0]  chk_crc_lsb;
  logic        dec_valid;
  logic        dec_accept;

  always #4 clk = ~clk;

  daf_addr_filter dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .chk_start   (chk_start),
    .chk_dest    (chk_dest),
    .chk_crc_lsb (chk_crc_lsb),
    .dec_valid   (dec_valid),
    .dec_accept  (dec_accept)
  );

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          acc;
    string       tag;
    logic [47:0] addr;
  } exp_t;
  exp_t exp_q[$];

  // shadow configuration kept by the bench from the register map
  bit          sh_promisc;
  bit          sh_allmulti;
  logic [47:0] sh_slot [5];
  logic [15:0] sh_hash [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic logic [31:0] crc_le(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 8; j++) begin
        if (c[0] ^ a[8*i + j]) c = (c >> 1) ^ 32'hEDB8_8320;
        else                   c = c >> 1;
      end
    end
    return c;
  endfunction

  function automatic bit model_accept(input logic [47:0] d);
    logic [31:0] c = crc_le(d);
    if (sh_promisc) return 1'b1;
    if (d == 48'hFFFF_FFFF_FFFF) return 1'b1;
    if (d[0] == 1'b0) return d == sh_slot[0];
    if (sh_allmulti) return 1'b1;
    for (int i = 0; i < 5; i++) if (d == sh_slot[i]) return 1'b1;
    return sh_hash[c[5:4]][15 - int'(c[3:0])];
  endfunction

  function automatic void shadow_apply(input logic [7:0] a, input logic [15:0] d);
    if (a == 8'h00) begin
      sh_promisc  = d[5];
      sh_allmulti = d[8];
    end
    for (int j = 0; j < 4; j++)
      if (int'(a) == 16 + 2*j) sh_hash[j] = d;
    for (int s = 0; s < 5; s++)
      for (int w = 0; w < 3; w++)
        if (int'(a) == 32 + 8*s + 2*w) sh_slot[s][16*w +: 16] = d;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    shadow_apply(a, d);
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic wr_slot(input int s, input logic [47:0] v);
    for (int w = 0; w < 3; w++) wr(8'(32 + 8*s + 2*w), v[16*w +: 16]);
  endtask

  // drive one start in the current cycle and push its expectation
  task automatic drive_start(input logic [47:0] d, input string tag);
    exp_t e;
    logic [31:0] c = crc_le(d);
    chk_start   = 1'b1;
    chk_dest    = d;
    chk_crc_lsb = c[5:0];
    e.acc  = model_accept(d);
    e.tag  = tag;
    e.addr = d;
    exp_q.push_back(e);
  endtask

  task automatic send(input logic [47:0] d, input string tag);
    @(negedge clk);
    drive_start(d, tag);
    @(negedge clk);
    chk_start = 1'b0;
  endtask

  // start and register write on the same edge
  task automatic send_with_write(input logic [47:0] d, input logic [7:0] a,
                                 input logic [15:0] v, input string tag);
    @(negedge clk);
    drive_start(d, tag);
    cfg_wr_en = 1'b1;
    cfg_addr  = a;
    cfg_wdata = v;
    shadow_apply(a, v);
    @(negedge clk);
    chk_start = 1'b0;
    cfg_wr_en = 1'b0;
  endtask

  // scoreboard monitor
  logic start_seen;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_seen <= 1'b0;
    else        start_seen <= chk_start;
  end

  always @(negedge clk) begin
    exp_t e;
    if (rst_n === 1'b1 && !finished) begin
      if (dec_valid !== 1'b0 || start_seen)
        check(dec_valid === start_seen, "R1", "valid timing", 64'(dec_valid), 64'(start_seen));
      if (dec_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "result with nothing pending", 64'(1), 64'(0));
        end else begin
          e = exp_q.pop_front();
          check(dec_accept === e.acc, e.tag, $sformatf("accept for %012h", e.addr),
                64'(dec_accept), 64'(e.acc));
        end
      end else if (dec_accept !== 1'b0) begin
        check(1'b0, "R1", "accept without valid", 64'(dec_accept), 64'(0));
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    logic [47:0] d;
    logic [31:0] c;
    rst_n       = 1'b0;
    cfg_wr_en   = 1'b0;
    cfg_addr    = '0;
    cfg_wdata   = '0;
    chk_start   = 1'b0;
    chk_dest    = '0;
    chk_crc_lsb = '0;
    sh_promisc  = 1'b0;
    sh_allmulti = 1'b0;
    sh_slot[0]  = '0;
    for (int s = 1; s < 5; s++) sh_slot[s] = '1;
    for (int j = 0; j < 4; j++) sh_hash[j] = '0;

    repeat (3) @(negedge clk);
    check(dec_valid === 1'b0 && dec_accept === 1'b0, "R2", "outputs in reset",
          64'({dec_valid, dec_accept}), 64'(0));
    rst_n = 1'b1;

    // R2: reset contents
    send(48'h0, "R2");                     // station slot is zero
    send(48'h0000_0000_0001, "R2");        // group, no slot, no hash bit
    send(48'h1234_5678_9A00, "R2");        // unicast elsewhere

    // R9/R3: program the station slot
    wr_slot(0, 48'h5544_3322_1100);
    send(48'h5544_3322_1100, "R9");
    send(48'h5545_3322_1100, "R3");
    send(48'h0, "R3");

    // R4: group address in extra slot 1, R3: unicast in extra slot 2
    wr_slot(1, 48'hA0B0_C0D0_E0F1);
    send(48'hA0B0_C0D0_E0F1, "R4");
    wr_slot(4, 48'h0F0E_0D0C_0B0B);
    send(48'h0F0E_0D0C_0B0B, "R4");
    wr_slot(2, 48'h6677_8899_AA02);
    send(48'h6677_8899_AA02, "R3");

    // R5: single hash bits aimed at chosen group addresses
    for (int k = 0; k < 8; k++) begin
      d = {40'hB2_907E_5C3A, 8'(8'h03 + 2*k)};
      c = crc_le(d);
      wr(8'(16 + 2*int'(c[5:4])), 16'(16'h8000 >> c[3:0]));
      send(d, "R5");
      send(d ^ 48'h0000_0000_0100, "R5");
      wr(8'(16 + 2*int'(c[5:4])), 16'h0000);
      send(d, "R5");
    end
    for (int j = 0; j < 4; j++) wr(8'(16 + 2*j), 16'hFFFF);
    send(48'h1357_9BDF_0241, "R5");
    send(48'hCAFE_F00D_0011, "R5");
    for (int j = 0; j < 4; j++) wr(8'(16 + 2*j), 16'h0000);
    send(48'hCAFE_F00D_0011, "R5");

    // R6: broadcast
    send(48'hFFFF_FFFF_FFFF, "R6");

    // R8: all-multicast
    wr(8'h00, 16'h0100);
    send(48'h2468_ACE0_1357, "R8");
    send(48'h2468_ACE0_1356, "R8");
    wr(8'h00, 16'h0000);
    send(48'h2468_ACE0_1357, "R8");

    // R7: promiscuous
    wr(8'h00, 16'h0020);
    send(48'h2468_ACE0_1356, "R7");
    send(48'h2468_ACE0_1357, "R7");
    wr(8'h00, 16'h0000);

    // R9: unmapped offsets leave state alone
    wr(8'h26, 16'hFFFF);
    wr(8'h0E, 16'hFFFF);
    wr(8'h18, 16'hFFFF);
    wr(8'h02, 16'h0120);
    send(48'h5544_3322_1100, "R9");
    send(48'h2468_ACE0_1356, "R9");
    send(48'h2468_ACE0_1357, "R9");

    // R10: same-edge write uses old configuration
    send_with_write(48'h7777_8888_9900, 8'h00, 16'h0020, "R10");
    send(48'h7777_8888_9900, "R10");
    send_with_write(48'h7777_8888_9900, 8'h00, 16'h0000, "R10");
    send(48'h7777_8888_9900, "R10");

    // R1: back-to-back starts
    @(negedge clk);
    drive_start(48'h5544_3322_1100, "R1");
    @(negedge clk);
    drive_start(48'h1111_2222_3300, "R1");
    @(negedge clk);
    drive_start(48'hFFFF_FFFF_FFFF, "R1");
    @(negedge clk);
    chk_start = 1'b0;

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R1", "pending results", 64'(exp_q.size()), 64'(0));
    finish_run();
  end

endmodule